// File: doc/BRIEF.md
# Small Computer Bus Host Port Bridge

This block sits between a processor's I/O port space and a narrow parallel disk bus of the SASI kind. The processor issues single-byte port accesses through a valid/ready request channel and receives one result per access on a valid/ready response channel. Five port addresses, counted from a configurable base, are decoded. One pulses the bus reset line. One asserts the selection line. One returns a status byte built from the synchronized bus control lines. The remaining two move one data byte each way. The bridge runs the REQ/ACK handshake for every data byte on its own, so software never toggles ACK by hand.

Bus control inputs (BSY, REQ, C/D, I/O, MSG and a separate presence signal) pass through a multi-stage synchronizer before any logic uses them. A data-port access stalls the request channel until the target has raised and then dropped REQ. Only then is the response produced. The request channel takes a new access only when the previous response has been taken, no byte transfer is pending, and no bus reset pulse is running. A response, once offered, stays unchanged until the consumer accepts it. Every accepted access gets exactly one response. Writes and unmapped accesses answer with 00h.

Top module: `sasi_host_bridge`

## Requirements
- R1: Out of reset, bus_ack, bus_sel, bus_rst, bus_data_oe and rsp_valid are low and req_ready is high.
- R2: A write to base+0 (default 40h) raises bus_rst for exactly RST_CYCLES clock cycles and drops bus_sel. req_ready stays low for the whole pulse.
- R3: A write to base+1 (41h) places the written byte on bus_data_out. bus_ack rises only after REQ has been seen high and stays high while REQ is high. It falls after REQ is seen low. The response appears only after bus_ack is low again.
- R4: bus_data_oe is high only while a base+1 write transfer is pending and the synchronized I/O line is low (host-to-target). It is never high for reads, for other ports, or while I/O is high.
- R5: A read from base+2 (42h) returns the byte present on bus_data_in when REQ was seen high, using the same ACK handshake as R3.
- R6: A write to base+3 (43h) raises bus_sel. bus_sel falls the cycle after BSY is seen high. While BSY is seen high the write does not raise bus_sel.
- R7: A read from base+6 (46h) returns BSY in bit 0, REQ in bit 1, C/D in bit 2, I/O in bit 3, MSG in bit 4 and the presence input in bit 5, all as synchronized levels. Bits 7:6 read as zero.
- R8: req_ready is low while rsp_valid is high. A held response keeps rsp_valid and rsp_rdata unchanged until rsp_ready is high. Each accepted access yields exactly one response, and every write answers 00h.
- R9: Accesses to unmapped addresses, and accesses in the wrong direction for a decoded port, leave bus_rst, bus_sel, bus_ack and bus_data_oe unchanged. Such reads return 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Port access request valid |
| req_ready | output | 1 | Bridge can accept an access |
| req_write | input | 1 | 1 = port write, 0 = port read |
| req_addr | input | ADDR_W | Port address |
| req_wdata | input | DATA_W | Write byte |
| rsp_valid | output | 1 | Access result valid |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_rdata | output | DATA_W | Read result (00h for writes) |
| bus_data_in | input | DATA_W | Bus data lines as seen from the bus |
| bus_data_out | output | DATA_W | Byte offered to the bus data lines |
| bus_data_oe | output | 1 | Drive enable for bus_data_out |
| bus_rst | output | 1 | Bus reset line |
| bus_sel | output | 1 | Bus selection line |
| bus_ack | output | 1 | Bus acknowledge line |
| bus_bsy | input | 1 | Target busy |
| bus_req | input | 1 | Target requests a byte transfer |
| bus_cd | input | 1 | Command/status (1) or data (0) phase |
| bus_io | input | 1 | 1 = target to host, 0 = host to target |
| bus_msg | input | 1 | Message phase |
| bus_present | input | 1 | Target presence indication |

## Verification
The bench aims at the handshake edges. If ACK rose before REQ, dropped while REQ was still high, or the response came out while ACK was still asserted, a target would miss or repeat a byte, and the target model in the bench catches each of these. Direction is tested by writing with I/O high and low and by reading: a design that drives the data lines on the wrong condition would fight the target. Other checks cover the exact reset pulse length, SEL dropping on BSY and being refused while BSY is high, the status bit order with bits 7:6 forced low, a held response under back-pressure, and unmapped or wrong-direction accesses, which must leave every bus line quiet.

// File: rtl/sasi_bridge_pkg.sv
package sasi_bridge_pkg;

  // Port offsets from the base address; the status bit order below is fixed.
  localparam int OFF_BUS_RESET = 0;
  localparam int OFF_DATA_WR   = 1;
  localparam int OFF_DATA_RD   = 2;
  localparam int OFF_SEL       = 3;
  localparam int OFF_STATUS    = 6;

  // Bit positions of the synchronized control vector and status byte.
  localparam int CTL_BSY     = 0;
  localparam int CTL_REQ     = 1;
  localparam int CTL_CD      = 2;
  localparam int CTL_IO      = 3;
  localparam int CTL_MSG     = 4;
  localparam int CTL_PRESENT = 5;
  localparam int CTL_W       = 6;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_BUS_RESET,
    OP_DATA_WR,
    OP_DATA_RD,
    OP_SEL,
    OP_STATUS
  } port_op_e;

  typedef enum logic [1:0] {
    XF_IDLE,
    XF_WAIT_REQ,
    XF_HOLD_ACK
  } xfer_state_e;

endpackage

// File: rtl/sasi_in_sync.sv
module sasi_in_sync #(
  parameter int WIDTH  = 6,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= '0;
    else        chain[0] <= async_in;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[g] <= '0;
      else        chain[g] <= chain[g-1];
    end
  end

  assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/sasi_port_decode.sv
module sasi_port_decode
  import sasi_bridge_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int BASE_ADDR = 'h40
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              write,
  output port_op_e          op
);

  localparam logic [ADDR_W-1:0] A_RESET  = ADDR_W'(BASE_ADDR + OFF_BUS_RESET);
  localparam logic [ADDR_W-1:0] A_WR     = ADDR_W'(BASE_ADDR + OFF_DATA_WR);
  localparam logic [ADDR_W-1:0] A_RD     = ADDR_W'(BASE_ADDR + OFF_DATA_RD);
  localparam logic [ADDR_W-1:0] A_SEL    = ADDR_W'(BASE_ADDR + OFF_SEL);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(BASE_ADDR + OFF_STATUS);

  always_comb begin
    op = OP_NONE;
    if (write) begin
      if (addr == A_RESET)      op = OP_BUS_RESET;
      else if (addr == A_WR)    op = OP_DATA_WR;
      else if (addr == A_SEL)   op = OP_SEL;
    end else begin
      if (addr == A_RD)         op = OP_DATA_RD;
      else if (addr == A_STATUS) op = OP_STATUS;
    end
  end

endmodule

// File: rtl/sasi_xfer_engine.sv
module sasi_xfer_engine
  import sasi_bridge_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_read,
  input  logic [DATA_W-1:0] wdata,
  input  logic              req_s,
  input  logic              io_s,
  input  logic [DATA_W-1:0] bus_din,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              ack,
  output logic [DATA_W-1:0] dout,
  output logic              doe
);

  xfer_state_e       state;
  logic              is_rd;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= XF_IDLE;
      is_rd  <= 1'b0;
      data_q <= '0;
      ack    <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        XF_IDLE: begin
          if (start) begin
            state  <= XF_WAIT_REQ;
            is_rd  <= start_read;
            data_q <= start_read ? '0 : wdata;
          end
        end
        XF_WAIT_REQ: begin
          // Target has set up the byte before raising REQ.
          if (req_s) begin
            ack   <= 1'b1;
            state <= XF_HOLD_ACK;
            if (is_rd) data_q <= bus_din;
          end
        end
        XF_HOLD_ACK: begin
          if (!req_s) begin
            ack   <= 1'b0;
            done  <= 1'b1;
            state <= XF_IDLE;
          end
        end
        default: state <= XF_IDLE;
      endcase
    end
  end

  assign busy  = (state != XF_IDLE);
  assign rdata = data_q;
  assign dout  = data_q;
  assign doe   = busy && !is_rd && !io_s;

endmodule

// File: rtl/sasi_line_ctrl.sv
module sasi_line_ctrl #(
  parameter int RST_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse_start,
  input  logic sel_set,
  input  logic bsy_s,
  output logic bus_rst,
  output logic bus_sel
);

  localparam int CNT_W = $clog2(RST_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(RST_CYCLES);

  logic [CNT_W-1:0] rst_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_cnt <= '0;
    end else if (pulse_start) begin
      rst_cnt <= CNT_LOAD;
    end else if (rst_cnt != '0) begin
      rst_cnt <= rst_cnt - 1'b1;
    end
  end

  assign bus_rst = (rst_cnt != '0);

  // A busy target, a new reset or a running reset all release SEL first.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_sel <= 1'b0;
    end else if (bsy_s || pulse_start || bus_rst) begin
      bus_sel <= 1'b0;
    end else if (sel_set) begin
      bus_sel <= 1'b1;
    end
  end

endmodule

// File: rtl/sasi_host_bridge.sv
module sasi_host_bridge
  import sasi_bridge_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter int BASE_ADDR   = 'h40,
  parameter int RST_CYCLES  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic [DATA_W-1:0] bus_data_in,
  output logic [DATA_W-1:0] bus_data_out,
  output logic              bus_data_oe,
  output logic              bus_rst,
  output logic              bus_sel,
  output logic              bus_ack,
  input  logic              bus_bsy,
  input  logic              bus_req,
  input  logic              bus_cd,
  input  logic              bus_io,
  input  logic              bus_msg,
  input  logic              bus_present
);

  logic [CTL_W-1:0] ctl_raw;
  logic [CTL_W-1:0] ctl_s;
  logic             req_s;
  logic             bsy_s;
  logic             io_s;

  port_op_e          op;
  logic              accept;
  logic              xfer_busy;
  logic              xfer_done;
  logic [DATA_W-1:0] xfer_rdata;
  logic              pend_rd;
  logic [DATA_W-1:0] status_byte;

  always_comb begin
    ctl_raw              = '0;
    ctl_raw[CTL_BSY]     = bus_bsy;
    ctl_raw[CTL_REQ]     = bus_req;
    ctl_raw[CTL_CD]      = bus_cd;
    ctl_raw[CTL_IO]      = bus_io;
    ctl_raw[CTL_MSG]     = bus_msg;
    ctl_raw[CTL_PRESENT] = bus_present;
  end

  sasi_in_sync #(
    .WIDTH  (CTL_W),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (ctl_raw),
    .sync_out (ctl_s)
  );

  assign req_s = ctl_s[CTL_REQ];
  assign bsy_s = ctl_s[CTL_BSY];
  assign io_s  = ctl_s[CTL_IO];

  sasi_port_decode #(
    .ADDR_W    (ADDR_W),
    .BASE_ADDR (BASE_ADDR)
  ) u_decode (
    .addr  (req_addr),
    .write (req_write),
    .op    (op)
  );

  assign req_ready = !rsp_valid && !xfer_busy && !bus_rst;
  assign accept    = req_valid && req_ready;

  sasi_xfer_engine #(
    .DATA_W (DATA_W)
  ) u_xfer (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (accept && (op == OP_DATA_WR || op == OP_DATA_RD)),
    .start_read (op == OP_DATA_RD),
    .wdata      (req_wdata),
    .req_s      (req_s),
    .io_s       (io_s),
    .bus_din    (bus_data_in),
    .busy       (xfer_busy),
    .done       (xfer_done),
    .rdata      (xfer_rdata),
    .ack        (bus_ack),
    .dout       (bus_data_out),
    .doe        (bus_data_oe)
  );

  sasi_line_ctrl #(
    .RST_CYCLES (RST_CYCLES)
  ) u_lines (
    .clk         (clk),
    .rst_n       (rst_n),
    .pulse_start (accept && op == OP_BUS_RESET),
    .sel_set     (accept && op == OP_SEL),
    .bsy_s       (bsy_s),
    .bus_rst     (bus_rst),
    .bus_sel     (bus_sel)
  );

  always_comb begin
    status_byte            = '0;
    status_byte[CTL_W-1:0] = ctl_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      pend_rd   <= 1'b0;
    end else begin
      if (rsp_valid && rsp_ready) rsp_valid <= 1'b0;
      if (accept) begin
        pend_rd <= (op == OP_DATA_RD);
        if (op != OP_DATA_WR && op != OP_DATA_RD) begin
          rsp_valid <= 1'b1;
          rsp_rdata <= (op == OP_STATUS) ? status_byte : '0;
        end
      end
      if (xfer_done) begin
        rsp_valid <= 1'b1;
        rsp_rdata <= pend_rd ? xfer_rdata : '0;
      end
    end
  end

endmodule

// File: rtl/sasi_host_bridge_chk.sv
module sasi_host_bridge_chk #(
  parameter int DATA_W     = 8,
  parameter int RST_CYCLES = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              bus_ack,
  input logic              bus_sel,
  input logic              bus_rst,
  input logic              bus_data_oe,
  input logic              req_s,
  input logic              bsy_s
);

  localparam int RUN_W = $clog2(RST_CYCLES + 2) + 1;
  logic [RUN_W-1:0] rst_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rst_run <= '0;
    else if (bus_rst) rst_run <= rst_run + 1'b1;
    else              rst_run <= '0;
  end

  assert_rst_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst |-> (rst_run < RUN_W'(RST_CYCLES)));

  assert_rst_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst |-> !req_ready);

  assert_ack_after_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_ack) |-> $past(req_s));

  assert_ack_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ack && !req_s) |=> !bus_ack);

  assert_ack_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ack && req_s) |=> bus_ack);

  assert_oe_in_xfer_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_data_oe |-> !req_ready);

  assert_sel_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bsy_s |=> !bus_sel);

  assert_sel_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_sel) |-> !$past(bsy_s));

  assert_rsp_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  assert_no_accept_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

endmodule

bind sasi_host_bridge sasi_host_bridge_chk #(
  .DATA_W     (DATA_W),
  .RST_CYCLES (RST_CYCLES)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_ready   (req_ready),
  .rsp_valid   (rsp_valid),
  .rsp_ready   (rsp_ready),
  .rsp_rdata   (rsp_rdata),
  .bus_ack     (bus_ack),
  .bus_sel     (bus_sel),
  .bus_rst     (bus_rst),
  .bus_data_oe (bus_data_oe),
  .req_s       (req_s),
  .bsy_s       (bsy_s)
);

// File: tb/sasi_host_bridge_test.sv
`timescale 1ns/1ps
module sasi_host_bridge_test;

  localparam int RST_CYC = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic       req_write = 1'b0;
  logic [7:0] req_addr = 8'h00;
  logic [7:0] req_wdata = 8'h00;
  logic       rsp_valid;
  logic       rsp_ready = 1'b1;
  logic [7:0] rsp_rdata;
  logic [7:0] bus_data_in = 8'h00;
  logic [7:0] bus_data_out;
  logic       bus_data_oe;
  logic       bus_rst;
  logic       bus_sel;
  logic       bus_ack;
  logic       bus_bsy = 1'b0;
  logic       bus_req = 1'b0;
  logic       bus_cd = 1'b0;
  logic       bus_io = 1'b0;
  logic       bus_msg = 1'b0;
  logic       bus_present = 1'b0;

  int total = 0;
  int bad = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  sasi_host_bridge #(.RST_CYCLES(RST_CYC)) uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .bus_data_in(bus_data_in), .bus_data_out(bus_data_out), .bus_data_oe(bus_data_oe),
    .bus_rst(bus_rst), .bus_sel(bus_sel), .bus_ack(bus_ack),
    .bus_bsy(bus_bsy), .bus_req(bus_req), .bus_cd(bus_cd), .bus_io(bus_io),
    .bus_msg(bus_msg), .bus_present(bus_present)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Driver: queue the expected result, then present the access.
  task automatic cpu_access(input bit wr, input logic [7:0] a, input logic [7:0] d,
                            input logic [7:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 300 && exp_q.size() != 0; i++) @(negedge clk);
    check(exp_q.size() == 0, "R8 missing response", exp_q.size(), 0);
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Target side of one byte transfer.
  task automatic target_xfer(input logic [7:0] drv, input bit exp_oe, input bit chk_data,
                             input logic [7:0] exp_data);
    int waited;
    int held;
    settle(6);
    check(bus_ack == 1'b0, "R3 ack before REQ", bus_ack, 0);
    bus_data_in = drv;
    bus_req = 1'b1;
    waited = 0;
    while (!bus_ack && waited < 20) begin @(negedge clk); waited++; end
    check(bus_ack == 1'b1, "R3 ack after REQ", bus_ack, 1);
    check(bus_data_oe == exp_oe, "R4 data drive enable", bus_data_oe, exp_oe);
    if (chk_data) check(bus_data_out == exp_data, "R3 write data on bus", bus_data_out, exp_data);
    held = 0;
    repeat (4) begin @(negedge clk); if (bus_ack) held++; end
    check(held == 4, "R3 ack held while REQ high", held, 4);
    bus_req = 1'b0;
    waited = 0;
    while (bus_ack && waited < 20) begin @(negedge clk); waited++; end
    check(bus_ack == 1'b0, "R3 ack release after REQ low", bus_ack, 0);
    bus_data_in = 8'h00;
  endtask

  initial begin
    fork
      begin : watchdog
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
      begin : monitor
        forever begin
          @(negedge clk);
          if (rst_n && rsp_valid && rsp_ready) begin
            if (exp_q.size() == 0) begin
              check(1'b0, "R8 unexpected response", rsp_rdata, 0);
            end else begin
              logic [7:0] e;
              string t;
              e = exp_q.pop_front();
              t = tag_q.pop_front();
              check(rsp_rdata == e, t, rsp_rdata, e);
              check(bus_ack == 1'b0, "R3 response after ack release", bus_ack, 0);
            end
          end
        end
      end
    join_none

    settle(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(bus_ack == 0 && bus_sel == 0 && bus_rst == 0, "R1 bus lines idle",
          {bus_ack, bus_sel, bus_rst}, 0);
    check(bus_data_oe == 0, "R1 data not driven", bus_data_oe, 0);
    check(rsp_valid == 0 && req_ready == 1, "R1 channel state", {rsp_valid, req_ready}, 1);

    // R7 status layout
    bus_bsy = 1; bus_req = 0; bus_cd = 1; bus_io = 0; bus_msg = 1; bus_present = 1;
    settle(4);
    cpu_access(0, 8'h46, 8'h00, 8'h35, "R7 status pattern a");
    drain();
    bus_bsy = 0; bus_req = 1; bus_cd = 0; bus_io = 1; bus_msg = 0; bus_present = 0;
    settle(4);
    cpu_access(0, 8'h46, 8'h00, 8'h0A, "R7 status pattern b");
    bus_bsy = 1; bus_req = 1; bus_cd = 1; bus_io = 1; bus_msg = 1; bus_present = 1;
    settle(4);
    cpu_access(0, 8'h46, 8'h00, 8'h3F, "R7 status all high, top bits zero");
    drain();
    bus_bsy = 0; bus_req = 0; bus_cd = 0; bus_io = 0; bus_msg = 0; bus_present = 0;
    settle(4);
    cpu_access(0, 8'h46, 8'h00, 8'h00, "R7 status all low");
    drain();

    // R6 select line
    cpu_access(1, 8'h43, 8'h00, 8'h00, "R8 write answers zero");
    drain();
    settle(1);
    check(bus_sel == 1, "R6 sel asserted", bus_sel, 1);
    bus_bsy = 1;
    settle(4);
    check(bus_sel == 0, "R6 sel released on BSY", bus_sel, 0);
    cpu_access(1, 8'h43, 8'h00, 8'h00, "R8 write answers zero");
    drain();
    settle(2);
    check(bus_sel == 0, "R6 sel refused while BSY", bus_sel, 0);
    bus_bsy = 0;
    settle(4);

    // R2 bus reset pulse
    cpu_access(1, 8'h43, 8'h00, 8'h00, "R8 write answers zero");
    drain();
    settle(1);
    check(bus_sel == 1, "R6 sel asserted before reset", bus_sel, 1);
    begin
      int hi;
      int blocked;
      hi = 0; blocked = 0;
      fork
        cpu_access(1, 8'h40, 8'h00, 8'h00, "R8 write answers zero");
        repeat (40) begin
          @(negedge clk);
          if (bus_rst) hi++;
          if (bus_rst && req_ready) blocked++;
        end
      join
      check(hi == RST_CYC, "R2 reset pulse length", hi, RST_CYC);
      check(blocked == 0, "R2 no accept during reset", blocked, 0);
      check(bus_sel == 0, "R2 sel cleared by reset", bus_sel, 0);
    end
    drain();

    // R3/R4 data writes, both directions of I/O
    bus_io = 0;
    settle(4);
    fork
      cpu_access(1, 8'h41, 8'hA5, 8'h00, "R3 data write response");
      target_xfer(8'h00, 1'b1, 1'b1, 8'hA5);
    join
    drain();
    check(bus_data_oe == 0, "R4 drive off after write", bus_data_oe, 0);
    bus_io = 1;
    settle(4);
    fork
      cpu_access(1, 8'h41, 8'h3C, 8'h00, "R3 data write response io high");
      target_xfer(8'h00, 1'b0, 1'b0, 8'h00);
    join
    drain();

    // R5 data reads
    fork
      cpu_access(0, 8'h42, 8'h00, 8'h5A, "R5 data read byte");
      target_xfer(8'h5A, 1'b0, 1'b0, 8'h00);
    join
    fork
      cpu_access(0, 8'h42, 8'h00, 8'hC3, "R5 data read second byte");
      target_xfer(8'hC3, 1'b0, 1'b0, 8'h00);
    join
    drain();
    bus_io = 0;
    settle(4);

    // R9 unmapped and wrong-direction accesses
    cpu_access(1, 8'h44, 8'hFF, 8'h00, "R9 unmapped write");
    cpu_access(1, 8'h46, 8'hFF, 8'h00, "R9 write to status port");
    drain();
    settle(3);
    check({bus_sel, bus_rst, bus_ack, bus_data_oe} == 4'b0, "R9 bus quiet after unmapped",
          {bus_sel, bus_rst, bus_ack, bus_data_oe}, 0);
    check(req_ready == 1, "R9 no transfer started", req_ready, 1);
    cpu_access(0, 8'h45, 8'h00, 8'h00, "R9 unmapped read");
    cpu_access(0, 8'h41, 8'h00, 8'h00, "R9 read of write-only port");
    cpu_access(0, 8'h40, 8'h00, 8'h00, "R9 read of reset port");
    drain();
    settle(2);
    check(bus_rst == 0 && req_ready == 1, "R9 reset port read has no effect",
          {bus_rst, req_ready}, 1);

    // R8 back-pressure
    bus_present = 1; bus_msg = 1;
    settle(4);
    rsp_ready = 1'b0;
    cpu_access(0, 8'h46, 8'h00, 8'h30, "R8 held status");
    settle(5);
    check(rsp_valid == 1, "R8 response held valid", rsp_valid, 1);
    check(rsp_rdata == 8'h30, "R8 response data stable", rsp_rdata, 8'h30);
    check(req_ready == 0, "R8 no accept while pending", req_ready, 0);
    rsp_ready = 1'b1;
    drain();

    settle(4);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule